// File: doc/BRIEF.md
# Key-Locked Configuration Index/Data Port

This block is the configuration front for a multi-port serial controller. It answers byte reads and writes on two neighbouring I/O addresses: the lower one holds an index that picks a register, the upper one carries that register's data. The configuration space is locked until a strap-selected key byte arrives on the index port twice in a row. A dedicated exit byte locks it again.

Once open, a device-select register chooses which per-port bank the bank-level indexes address. Global identification registers are read-only. Each serial port has a bank with its 16-bit I/O base, an interrupt control byte and a FIFO control byte. The bank contents drive decoded configuration outputs toward the serial cores.

The bus cycle front end and the serial cores themselves are outside this block. It sees plain one-cycle read and write strobes with a 16-bit address.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the port is locked (`cfgActive` low), device select is 0, each bank's base address equals its slice of `DEV_BASES` (device d at bits d*16+15:d*16), and all interrupt and FIFO control bytes are zero.
- R2: While locked, a read of either port returns 0xFF, and a data-port write changes no register.
- R3: Configuration opens only after the key byte (strap `KEY_SEL`: 0→0x77, 1→0xA0, 2→0x87, 3→0x67) is written to the index port on two successive index-port writes. `cfgActive` is high after the edge that samples the second write.
- R4: An index-port write of any other byte between the two key writes restarts the sequence.
- R5: Writing 0xAA to the index port while open locks the port; 0xAA is not stored as an index.
- R6: The identification registers read as follows: index 0x20 gives `CHIP_ID[7:0]`, 0x21 gives `CHIP_ID[15:8]`, 0x23 gives 0x19 and 0x24 gives 0x34. Writes to these indexes have no effect.
- R7: Index 0x07 is the device-select register and is readable and writable. A value at or above `NUM_DEV` selects no bank: bank indexes read 0 and writes to them are ignored.
- R8: Bank index 0x60 holds the base high byte and 0x61 the base low byte. Both are writable and appear on `devBase`.
- R9: Bank index 0x70 is interrupt control. Bit 4 drives `devIrqShare`. `devIrqEdge` is high when bits 6:5 equal 01; value 00 means level, active low.
- R10: Bank index 0xF6 is FIFO control. `devFifoDeep` is high when bits 1:0 equal 11 (128-byte FIFO). `devRxThr4x` is high when bits 5:4 equal 10.
- R11: Indexes that are not implemented read as 0. A read of the index port while open returns the current index.
- R12: Accesses to addresses other than the two ports (base from `BASE_SEL`: 0→0x4E, 1→0x2E, data port at base+1) are ignored.
- R13: `ioRdData` is updated on the clock edge that samples a read of either port, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | I/O address of the access |
| ioWrEn | input | 1 | Write strobe, one cycle per byte |
| ioRdEn | input | 1 | Read strobe, one cycle per byte |
| ioWrData | input | 8 | Write data |
| ioRdData | output | 8 | Registered read data |
| cfgActive | output | 1 | High while configuration is open |
| devBase | output | NUM_DEV*16 | Per-device I/O base, device d at bits d*16+15:d*16 |
| devIrqShare | output | NUM_DEV | Per-device interrupt sharing enable |
| devIrqEdge | output | NUM_DEV | Per-device edge/active-high interrupt mode |
| devFifoDeep | output | NUM_DEV | Per-device 128-byte FIFO select |
| devRxThr4x | output | NUM_DEV | Per-device 4x receive threshold select |

## Verification
Every result of this block is due one clock edge after its strobe. A key, exit or index write changes `cfgActive` or the index at the edge that samples it. A data write changes a bank register, and with it the decoded outputs, at that same edge. A read loads `ioRdData` at the edge that samples the strobe. The bench drives each strobe for a single cycle from the falling edge and samples all outputs at the following falling edge, which is after the one register stage. Ignored writes are checked by reading the affected register back through the data port, or by watching the decoded outputs, after the port has been reopened.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_HALF   = 2'd1,
    ST_OPEN   = 2'd2
  } lock_state_t;

  // strobes from control to register datapath
  typedef struct packed {
    logic       dataWr;
    logic       dataRd;
    logic       idxRd;
    logic       lockedRd;
    logic [7:0] index;
  } cfg_strobe_t;

  localparam logic [7:0] EXIT_BYTE  = 8'hAA;
  localparam logic [7:0] IDX_DEVSEL = 8'h07;
  localparam logic [7:0] IDX_CHIPLO = 8'h20;
  localparam logic [7:0] IDX_CHIPHI = 8'h21;
  localparam logic [7:0] IDX_VEND1  = 8'h23;
  localparam logic [7:0] IDX_VEND2  = 8'h24;
  localparam logic [7:0] IDX_BASEHI = 8'h60;
  localparam logic [7:0] IDX_BASELO = 8'h61;
  localparam logic [7:0] IDX_IRQ    = 8'h70;
  localparam logic [7:0] IDX_FIFO   = 8'hF6;
  localparam logic [7:0] VEND1_VAL  = 8'h19;
  localparam logic [7:0] VEND2_VAL  = 8'h34;

  function automatic logic [7:0] unlockKey(input int sel);
    case (sel)
      0:       return 8'h77;
      1:       return 8'hA0;
      2:       return 8'h87;
      default: return 8'h67;
    endcase
  endfunction

  function automatic logic [15:0] portBase(input int sel);
    return (sel == 0) ? 16'h004E : 16'h002E;
  endfunction

endpackage

// File: rtl/keyed_cfg_ctrl.sv
module keyed_cfg_ctrl
  import keyed_cfg_pkg::*;
#(
  parameter int KEY_SEL  = 2,
  parameter int BASE_SEL = 0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] ioAddr,
  input  logic        ioWrEn,
  input  logic        ioRdEn,
  input  logic [7:0]  ioWrData,
  output cfg_strobe_t strobe,
  output logic        cfgActive
);

  localparam logic [7:0]  KEY       = unlockKey(KEY_SEL);
  localparam logic [15:0] IDX_ADDR  = portBase(BASE_SEL);
  localparam logic [15:0] DATA_ADDR = IDX_ADDR + 16'd1;

  lock_state_t stateQ;
  logic [7:0]  indexQ;
  logic        idxHit, dataHit, idxWrite, isOpen;

  assign idxHit   = (ioAddr == IDX_ADDR);
  assign dataHit  = (ioAddr == DATA_ADDR);
  assign idxWrite = ioWrEn && idxHit;
  assign isOpen   = (stateQ == ST_OPEN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_LOCKED;
      indexQ <= 8'h00;
    end else if (idxWrite) begin
      case (stateQ)
        ST_LOCKED: stateQ <= (ioWrData == KEY) ? ST_HALF : ST_LOCKED;
        ST_HALF:   stateQ <= (ioWrData == KEY) ? ST_OPEN : ST_LOCKED;
        default: begin
          if (ioWrData == EXIT_BYTE) stateQ <= ST_LOCKED;
          else                       indexQ <= ioWrData;
        end
      endcase
    end
  end

  always_comb begin
    strobe.dataWr   = isOpen && ioWrEn && dataHit;
    strobe.dataRd   = isOpen && ioRdEn && dataHit;
    strobe.idxRd    = isOpen && ioRdEn && idxHit;
    strobe.lockedRd = !isOpen && ioRdEn && (idxHit || dataHit);
    strobe.index    = indexQ;
  end

  assign cfgActive = isOpen;

  // R3: opening always follows a key write to the index port
  assert_open_after_key_R3: assert property (@(posedge clk) disable iff (!rstN)
    (isOpen && $past(stateQ) != ST_OPEN) |-> $past(idxWrite && ioWrData == KEY));

  // R5: the exit byte locks the port
  assert_exit_locks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (isOpen && idxWrite && ioWrData == EXIT_BYTE) |=> (stateQ == ST_LOCKED));

  // R12: index only moves on an index-port write
  assert_index_on_write_R12: assert property (@(posedge clk) disable iff (!rstN)
    !idxWrite |=> $stable(indexQ));

endmodule

// File: rtl/keyed_cfg_bank.sv
module keyed_cfg_bank
  import keyed_cfg_pkg::*;
#(
  parameter int                   NUM_DEV   = 4,
  parameter logic [15:0]          CHIP_ID   = 16'h1602,
  parameter logic [NUM_DEV*16-1:0] DEV_BASES = {16'h02E8, 16'h03E8, 16'h02F8, 16'h03F8}
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cfg_strobe_t           strobe,
  input  logic [7:0]            ioWrData,
  output logic [7:0]            ioRdData,
  output logic [NUM_DEV*16-1:0] devBase,
  output logic [NUM_DEV-1:0]    devIrqShare,
  output logic [NUM_DEV-1:0]    devIrqEdge,
  output logic [NUM_DEV-1:0]    devFifoDeep,
  output logic [NUM_DEV-1:0]    devRxThr4x
);

  localparam int         DEV_W     = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam logic [7:0] DEV_LIMIT = 8'(NUM_DEV);

  logic [7:0]       devSelQ;
  logic [15:0]      baseQ [NUM_DEV];
  logic [7:0]       irqQ  [NUM_DEV];
  logic [7:0]       fifoQ [NUM_DEV];
  logic             bankHit;
  logic [DEV_W-1:0] bankIdx;
  logic [7:0]       readMux;

  assign bankHit = (devSelQ < DEV_LIMIT);
  assign bankIdx = devSelQ[DEV_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devSelQ <= 8'h00;
      for (int d = 0; d < NUM_DEV; d++) begin
        baseQ[d] <= DEV_BASES[d*16 +: 16];
        irqQ[d]  <= 8'h00;
        fifoQ[d] <= 8'h00;
      end
    end else if (strobe.dataWr) begin
      if (strobe.index == IDX_DEVSEL) begin
        devSelQ <= ioWrData;
      end else if (bankHit) begin
        for (int d = 0; d < NUM_DEV; d++) begin
          if (DEV_W'(d) == bankIdx) begin
            case (strobe.index)
              IDX_BASEHI: baseQ[d][15:8] <= ioWrData;
              IDX_BASELO: baseQ[d][7:0]  <= ioWrData;
              IDX_IRQ:    irqQ[d]        <= ioWrData;
              IDX_FIFO:   fifoQ[d]       <= ioWrData;
              default:    ;
            endcase
          end
        end
      end
    end
  end

  always_comb begin
    readMux = 8'h00;
    case (strobe.index)
      IDX_DEVSEL: readMux = devSelQ;
      IDX_CHIPLO: readMux = CHIP_ID[7:0];
      IDX_CHIPHI: readMux = CHIP_ID[15:8];
      IDX_VEND1:  readMux = VEND1_VAL;
      IDX_VEND2:  readMux = VEND2_VAL;
      IDX_BASEHI: if (bankHit) readMux = baseQ[bankIdx][15:8];
      IDX_BASELO: if (bankHit) readMux = baseQ[bankIdx][7:0];
      IDX_IRQ:    if (bankHit) readMux = irqQ[bankIdx];
      IDX_FIFO:   if (bankHit) readMux = fifoQ[bankIdx];
      default:    readMux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                ioRdData <= 8'hFF;
    else if (strobe.lockedRd) ioRdData <= 8'hFF;
    else if (strobe.idxRd)    ioRdData <= strobe.index;
    else if (strobe.dataRd)   ioRdData <= readMux;
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    assign devBase[g*16 +: 16] = baseQ[g];
    assign devIrqShare[g]      = irqQ[g][4];
    assign devIrqEdge[g]       = (irqQ[g][6:5] == 2'b01);
    assign devFifoDeep[g]      = (fifoQ[g][1:0] == 2'b11);
    assign devRxThr4x[g]       = (fifoQ[g][5:4] == 2'b10);
  end

  // R2: a locked read returns all ones
  assert_locked_read_ff_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lockedRd |=> (ioRdData == 8'hFF));

  // R7: device select only moves on a data write to its index
  assert_devsel_on_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(devSelQ) |-> $past(strobe.dataWr && strobe.index == IDX_DEVSEL));

  // R8: bank bases hold when no data write is made
  assert_base_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.dataWr |=> $stable(devBase));

  // R13: read data holds without a read strobe
  assert_rd_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.lockedRd || strobe.idxRd || strobe.dataRd) |=> $stable(ioRdData));

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import keyed_cfg_pkg::*;
#(
  parameter int                    NUM_DEV   = 4,
  parameter int                    KEY_SEL   = 2,
  parameter int                    BASE_SEL  = 0,
  parameter logic [15:0]           CHIP_ID   = 16'h1602,
  parameter logic [NUM_DEV*16-1:0] DEV_BASES = {16'h02E8, 16'h03E8, 16'h02F8, 16'h03F8}
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [15:0]           ioAddr,
  input  logic                  ioWrEn,
  input  logic                  ioRdEn,
  input  logic [7:0]            ioWrData,
  output logic [7:0]            ioRdData,
  output logic                  cfgActive,
  output logic [NUM_DEV*16-1:0] devBase,
  output logic [NUM_DEV-1:0]    devIrqShare,
  output logic [NUM_DEV-1:0]    devIrqEdge,
  output logic [NUM_DEV-1:0]    devFifoDeep,
  output logic [NUM_DEV-1:0]    devRxThr4x
);

  cfg_strobe_t strobe;

  keyed_cfg_ctrl #(
    .KEY_SEL (KEY_SEL),
    .BASE_SEL(BASE_SEL)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ioAddr   (ioAddr),
    .ioWrEn   (ioWrEn),
    .ioRdEn   (ioRdEn),
    .ioWrData (ioWrData),
    .strobe   (strobe),
    .cfgActive(cfgActive)
  );

  keyed_cfg_bank #(
    .NUM_DEV  (NUM_DEV),
    .CHIP_ID  (CHIP_ID),
    .DEV_BASES(DEV_BASES)
  ) u_bank (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .ioWrData   (ioWrData),
    .ioRdData   (ioRdData),
    .devBase    (devBase),
    .devIrqShare(devIrqShare),
    .devIrqEdge (devIrqEdge),
    .devFifoDeep(devFifoDeep),
    .devRxThr4x (devRxThr4x)
  );

endmodule

// File: tb/keyed_cfg_port_test.sv
module keyed_cfg_port_test;

  localparam int CLK_PERIOD = 10;
  localparam int NDEV = 4;
  localparam logic [15:0] IDXP = 16'h004E;
  localparam logic [15:0] DATP = 16'h004F;
  localparam logic [7:0]  KEY  = 8'h87;
  localparam logic [63:0] BASES = {16'h02E8, 16'h03E8, 16'h02F8, 16'h03F8};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ioAddr = 16'h0;
  logic        ioWrEn = 1'b0;
  logic        ioRdEn = 1'b0;
  logic [7:0]  ioWrData = 8'h0;
  logic [7:0]  ioRdData;
  logic        cfgActive;
  logic [63:0] devBase;
  logic [3:0]  devIrqShare, devIrqEdge, devFifoDeep, devRxThr4x;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_cfg_port uut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .cfgActive(cfgActive),
    .devBase(devBase), .devIrqShare(devIrqShare), .devIrqEdge(devIrqEdge),
    .devFifoDeep(devFifoDeep), .devRxThr4x(devRxThr4x)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ioWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWrEn = 1'b1;
    @(negedge clk);
    ioWrEn = 1'b0;
  endtask

  task automatic ioRead(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioRdEn = 1'b1;
    @(negedge clk);
    ioRdEn = 1'b0;
    d = ioRdData;
  endtask

  task automatic unlock();
    ioWrite(IDXP, KEY);
    ioWrite(IDXP, KEY);
  endtask

  task automatic regWr(input logic [7:0] idx, input logic [7:0] d);
    ioWrite(IDXP, idx);
    ioWrite(DATP, d);
  endtask

  task automatic regRd(input logic [7:0] idx, output logic [7:0] d);
    ioWrite(IDXP, idx);
    ioRead(DATP, d);
  endtask

  task automatic testReset();
    check("R1 locked", 64'(cfgActive), 64'd0);
    check("R1 bases", devBase, BASES);
    check("R1 irq", 64'({devIrqShare, devIrqEdge}), 64'd0);
    check("R1 fifo", 64'({devFifoDeep, devRxThr4x}), 64'd0);
  endtask

  task automatic testLocked();
    logic [7:0] v;
    unlock();
    ioWrite(IDXP, 8'h61);
    ioWrite(IDXP, 8'hAA);
    ioRead(DATP, v);
    check("R2 locked data read", 64'(v), 64'hFF);
    ioRead(IDXP, v);
    check("R2 locked index read", 64'(v), 64'hFF);
    ioWrite(DATP, 8'h12);
    check("R2 base untouched", devBase, BASES);
    unlock();
    ioRead(DATP, v);
    check("R2 reg readback", 64'(v), 64'hF8);
    ioWrite(IDXP, 8'hAA);
  endtask

  task automatic testUnlock();
    ioWrite(IDXP, KEY);
    check("R3 one key", 64'(cfgActive), 64'd0);
    ioWrite(IDXP, KEY);
    check("R3 two keys", 64'(cfgActive), 64'd1);
    ioWrite(IDXP, 8'hAA);
    check("R5 exit", 64'(cfgActive), 64'd0);
  endtask

  task automatic testRestart();
    ioWrite(IDXP, KEY);
    ioWrite(IDXP, 8'h55);
    ioWrite(IDXP, KEY);
    check("R4 interrupted", 64'(cfgActive), 64'd0);
    ioWrite(IDXP, KEY);
    check("R4 fresh pair", 64'(cfgActive), 64'd1);
    ioWrite(IDXP, 8'hAA);
  endtask

  task automatic testIds();
    logic [7:0] v;
    unlock();
    regRd(8'h20, v); check("R6 chip lo", 64'(v), 64'h02);
    regRd(8'h21, v); check("R6 chip hi", 64'(v), 64'h16);
    regRd(8'h23, v); check("R6 vendor1", 64'(v), 64'h19);
    regRd(8'h24, v); check("R6 vendor2", 64'(v), 64'h34);
    regWr(8'h23, 8'h00);
    regRd(8'h23, v); check("R6 read-only", 64'(v), 64'h19);
  endtask

  task automatic testDevSel();
    logic [7:0] v;
    regWr(8'h07, 8'h02);
    regRd(8'h07, v); check("R7 devsel readback", 64'(v), 64'h02);
    regRd(8'h61, v); check("R7 dev2 base lo", 64'(v), 64'hE8);
    regRd(8'h60, v); check("R7 dev2 base hi", 64'(v), 64'h03);
    regWr(8'h07, 8'h05);
    regRd(8'h60, v); check("R7 no bank read", 64'(v), 64'h00);
    regWr(8'h60, 8'h77);
    check("R7 no bank write", devBase, BASES);
  endtask

  task automatic testBase();
    logic [7:0] v;
    regWr(8'h07, 8'h01);
    regWr(8'h60, 8'h12);
    regWr(8'h61, 8'h34);
    check("R8 dev1 base out", 64'(devBase[31:16]), 64'h1234);
    check("R8 dev0 kept", 64'(devBase[15:0]), 64'h03F8);
    regRd(8'h61, v); check("R8 base lo readback", 64'(v), 64'h34);
  endtask

  task automatic testIrq();
    logic [7:0] v;
    regWr(8'h07, 8'h03);
    regWr(8'h70, 8'h30);
    check("R9 share", 64'(devIrqShare), 64'h8);
    check("R9 edge", 64'(devIrqEdge), 64'h8);
    regWr(8'h70, 8'h10);
    check("R9 level", 64'(devIrqEdge), 64'h0);
    regRd(8'h70, v); check("R9 readback", 64'(v), 64'h10);
  endtask

  task automatic testFifo();
    regWr(8'hF6, 8'h23);
    check("R10 deep", 64'(devFifoDeep), 64'h8);
    check("R10 thr4x", 64'(devRxThr4x), 64'h8);
    regWr(8'hF6, 8'h13);
    check("R10 thr other", 64'(devRxThr4x), 64'h0);
    check("R10 deep kept", 64'(devFifoDeep), 64'h8);
  endtask

  task automatic testMisc();
    logic [7:0] v;
    regRd(8'h55, v); check("R11 unimplemented", 64'(v), 64'h00);
    ioWrite(IDXP, 8'h70);
    ioRead(IDXP, v); check("R11 index read", 64'(v), 64'h70);
    ioRead(16'h0050, v); check("R13 hold", 64'(v), 64'h70);
    ioWrite(IDXP, 8'hAA);
    ioWrite(16'h004D, KEY);
    ioWrite(16'h004D, KEY);
    check("R12 foreign address", 64'(cfgActive), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLocked();
    testUnlock();
    testRestart();
    testIds();
    testDevSel();
    testBase();
    testIrq();
    testFifo();
    testMisc();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule